// File: doc/BRIEF.md
# Hot-Plug Slot Register Block

This block holds the control, status and capability words of one hot-plug slot behind a downstream port. Software reaches them through a word-addressed configuration port with byte enables, and the slot hardware reports physical events on two strobe inputs. The events are a device being inserted and a request to remove one. The block records these events as sticky status bits. Every write that touches the control half of the slot word is treated as one command that completes at once.

The block also produces the interrupt request for the slot. An interrupt is pending when the global hot-plug interrupt enable is set and some event is both flagged in status and enabled in control. If message signalling is off, the level output follows the pending condition. If message signalling is on, a one-cycle notify strobe is issued with a programmed 5-bit vector each time the condition becomes true. A control command can also toggle the slot interlock. A command that switches the power controller off with the power indicator off detaches a present device.

Top module: `hp_slot_ctl`

## Requirements
- R1: After a synchronous reset the slot word reads 0x000000C0, meaning control has the attention indicator field (bits 7:6) at off = 2'b11 and all else clear, and status is clear. The config word reads 0, and the level, notify, detach and busy outputs are low.
- R2: With message mode off, irq_level_o is high one cycle after a state change exactly when control bit 5 (interrupt enable) is set and (status & control & 0x0019) is nonzero. The events are button at bit 0, presence-changed at bit 3 and command-done at bit 4.
- R3: With message mode on (config bit 8), msg_notify_o pulses for one cycle with msg_vec_o equal to config bits 4:0 when the pending condition goes from false to true. No pulse is issued while it stays true, and the level stays low.
- R4: A write to the slot word (address 1) with byte enable 0 or 1 set is one command. Control bits 0 and 3..10 take the enabled bytes, and status bit 4 (command done, slot word bit 20) is set.
- R5: Control bit 11 (interlock toggle) always reads 0. Writing it as 1 in a command inverts status bit 7 (interlocked, slot word bit 23).
- R6: A command that leaves control bit 10 (power off) set and control bits 9:8 at 2'b11 while status bit 6 (present) is set clears present, sets status bit 3 and pulses detach_o.
- R7: A hot-add event sets status bits 6, 3 and 0. An unplug request sets status bit 0 only.
- R8: Status bits 0, 3 and 4 are write-one-to-clear through byte enable 2 of the slot word. Other status bits ignore such writes, and the level output drops once nothing is pending.
- R9: A hot-add event while interlocked pulses busy_err_o and leaves status unchanged.
- R10: Only enabled bytes are written. The capability word (address 2) is read-only and reads SLOT_NUM<<19 | 0x00020079 (0x003A0079 by default). A write carrying only byte enable 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe, data returned next cycle |
| cfg_addr | input | ADDR_W | Word address: 0 config, 1 slot, 2 capability |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Registered read data |
| evt_hot_add | input | 1 | Device inserted strobe |
| evt_unplug_req | input | 1 | Removal request strobe |
| irq_level_o | output | 1 | Level interrupt when message mode is off |
| msg_notify_o | output | 1 | One-cycle message request |
| msg_vec_o | output | VEC_W | Message vector |
| detach_o | output | 1 | One-cycle device detach strobe |
| busy_err_o | output | 1 | One-cycle hot-add rejection strobe |

## Verification
The assertions watch four things on every cycle. The level output must never be high without the interrupt enable or while message mode is on. Notify must never last two cycles. Every command must leave command-done set and every lock-toggle write must flip the interlock. Detach must always coincide with an absent, changed slot, and busy must only follow an interlocked state. Only the bench's scenarios can show that the exact pending equation, pulse-on-rise without repeats, byte-lane masking, write-one-to-clear and read-back values match the requirements. The bench compares these against a reference model under directed corner cases and seeded random traffic.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  // slot control bit positions
  localparam int C_BTN_EN     = 0;
  localparam int C_PDCHG_EN   = 3;
  localparam int C_CMD_EN     = 4;
  localparam int C_IRQ_EN     = 5;
  localparam int C_ATTN_LO    = 6;
  localparam int C_PWR_IND_LO = 8;
  localparam int C_PWR_OFF    = 10;
  localparam int C_LOCK_TGL   = 11;
  // slot status bit positions
  localparam int S_BTN      = 0;
  localparam int S_PDCHG    = 3;
  localparam int S_CMD_DONE = 4;
  localparam int S_PRESENT  = 6;
  localparam int S_LOCKED   = 7;

  localparam logic [1:0]  IND_OFF    = 2'b11;
  localparam logic [15:0] EVT_MASK   = 16'h0019;
  localparam logic [15:0] CTL_WMASK  = 16'h07F9;
  localparam logic [15:0] CTL_RST    = 16'h00C0;
  localparam logic [15:0] HOTADD_SET = 16'h0049;

  function automatic logic pending_f(input logic [15:0] ctl, input logic [15:0] sta);
    return ctl[C_IRQ_EN] && (|(ctl & sta & EVT_MASK));
  endfunction
endpackage

// File: rtl/hp_slot_state.sv
module hp_slot_state
  import hp_slot_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int LANES = HALF_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              sta_wr,
  input  logic [LANES-1:0]  ctl_be,
  input  logic [LANES-1:0]  sta_be,
  input  logic [2*HALF_W-1:0] wdata,
  input  logic              hot_add,
  input  logic              unplug_req,
  output logic [HALF_W-1:0] ctl_q,
  output logic [HALF_W-1:0] sta_q,
  output logic [HALF_W-1:0] ctl_nx,
  output logic [HALF_W-1:0] sta_nx,
  output logic              detach_o,
  output logic              busy_o
);
  logic [HALF_W-1:0] clr_lanes;
  logic              detach_n, busy_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign clr_lanes[g*8 +: 8] = {8{sta_be[g]}};
  end

  always_comb begin
    ctl_nx   = ctl_q;
    sta_nx   = sta_q;
    detach_n = 1'b0;
    busy_n   = 1'b0;
    if (sta_wr)
      sta_nx = sta_nx & ~(wdata[2*HALF_W-1:HALF_W] & EVT_MASK & clr_lanes);
    if (unplug_req)
      sta_nx[S_BTN] = 1'b1;
    if (hot_add) begin
      if (sta_q[S_LOCKED]) busy_n = 1'b1;
      else                 sta_nx = sta_nx | HOTADD_SET;
    end
    if (ctl_wr) begin
      for (int b = 0; b < LANES; b++)
        if (ctl_be[b])
          ctl_nx[b*8 +: 8] = (ctl_q[b*8 +: 8] & ~CTL_WMASK[b*8 +: 8]) |
                             (wdata[b*8 +: 8] & CTL_WMASK[b*8 +: 8]);
      if (ctl_be[C_LOCK_TGL/8] && wdata[C_LOCK_TGL])
        sta_nx[S_LOCKED] = ~sta_q[S_LOCKED];
      if (sta_nx[S_PRESENT] && ctl_nx[C_PWR_OFF] &&
          ctl_nx[C_PWR_IND_LO +: 2] == IND_OFF) begin
        sta_nx[S_PRESENT] = 1'b0;
        sta_nx[S_PDCHG]   = 1'b1;
        detach_n          = 1'b1;
      end
      sta_nx[S_CMD_DONE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= CTL_RST;
      sta_q    <= '0;
      detach_o <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      ctl_q    <= ctl_nx;
      sta_q    <= sta_nx;
      detach_o <= detach_n;
      busy_o   <= busy_n;
    end
  end

  // R4: every command leaves command-done set
  a_r4_cmd_done: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> sta_q[S_CMD_DONE]);
  // R5: a lock-toggle write flips the interlock
  a_r5_lock_flip: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_be[C_LOCK_TGL/8] && wdata[C_LOCK_TGL]) |=>
    (sta_q[S_LOCKED] != $past(sta_q[S_LOCKED])));
  // R6: detach only with an absent, changed slot
  a_r6_detach_state: assert property (@(posedge clk) disable iff (rst)
    detach_o |-> (!sta_q[S_PRESENT] && sta_q[S_PDCHG]));
  // R9: busy only after an interlocked state
  a_r9_busy_locked: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> $past(sta_q[S_LOCKED]));
  // R7: accepted hot-add sets its three bits
  a_r7_hot_add: assert property (@(posedge clk) disable iff (rst)
    (hot_add && !sta_q[S_LOCKED] && !ctl_wr) |=>
    (sta_q[S_PRESENT] && sta_q[S_PDCHG] && sta_q[S_BTN]));
endmodule

// File: rtl/hp_irq_gen.sv
module hp_irq_gen
  import hp_slot_pkg::*;
#(
  parameter int VEC_W  = 5,
  parameter int HALF_W = 16,
  localparam int MODE_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_be,
  input  logic [15:0]       wdata,
  input  logic [HALF_W-1:0] ctl_nx,
  input  logic [HALF_W-1:0] sta_nx,
  output logic [VEC_W-1:0]  vec_o,
  output logic              mode_o,
  output logic              irq_level_o,
  output logic              notify_o
);
  logic [VEC_W-1:0] vec_n;
  logic             mode_n, pend_n, pend_q;

  always_comb begin
    vec_n  = (cfg_wr && cfg_be[0]) ? wdata[VEC_W-1:0] : vec_o;
    mode_n = (cfg_wr && cfg_be[1]) ? wdata[MODE_BIT]  : mode_o;
    pend_n = pending_f(ctl_nx, sta_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o       <= '0;
      mode_o      <= 1'b0;
      pend_q      <= 1'b0;
      irq_level_o <= 1'b0;
      notify_o    <= 1'b0;
    end else begin
      vec_o       <= vec_n;
      mode_o      <= mode_n;
      pend_q      <= pend_n;
      irq_level_o <= !mode_n && pend_n;
      notify_o    <= mode_n && pend_n && !pend_q;
    end
  end

  // R3: the message strobe never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    notify_o |=> !notify_o);
  // R3: notify only in message mode
  a_r3_msg_mode: assert property (@(posedge clk) disable iff (rst)
    notify_o |-> mode_o);
endmodule

// File: rtl/hp_slot_ctl.sv
module hp_slot_ctl
  import hp_slot_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int VEC_W     = 5,
  parameter int SLOT_NUM  = 7,
  parameter int CFG_ADDR  = 0,
  parameter int SLOT_ADDR = 1,
  parameter int CAP_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [3:0]        cfg_be,
  output logic [31:0]       cfg_rdata,
  input  logic              evt_hot_add,
  input  logic              evt_unplug_req,
  output logic              irq_level_o,
  output logic              msg_notify_o,
  output logic [VEC_W-1:0]  msg_vec_o,
  output logic              detach_o,
  output logic              busy_err_o
);
  localparam int HALF_W = 16;
  localparam logic [31:0] CAP_WORD = (32'(SLOT_NUM) << 19) | 32'h0002_0079;

  logic              slot_sel, cfg_sel, ctl_wr, sta_wr, mode;
  logic [HALF_W-1:0] ctl_q, sta_q, ctl_nx, sta_nx;
  logic [31:0]       rd_word;

  assign slot_sel = cfg_wr && (cfg_addr == ADDR_W'(SLOT_ADDR));
  assign cfg_sel  = cfg_wr && (cfg_addr == ADDR_W'(CFG_ADDR));
  assign ctl_wr   = slot_sel && (|cfg_be[1:0]);
  assign sta_wr   = slot_sel && (|cfg_be[3:2]);

  hp_slot_state #(.HALF_W(HALF_W)) u_state (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .sta_wr(sta_wr),
    .ctl_be(cfg_be[1:0]), .sta_be(cfg_be[3:2]), .wdata(cfg_wdata),
    .hot_add(evt_hot_add), .unplug_req(evt_unplug_req),
    .ctl_q(ctl_q), .sta_q(sta_q), .ctl_nx(ctl_nx), .sta_nx(sta_nx),
    .detach_o(detach_o), .busy_o(busy_err_o)
  );

  hp_irq_gen #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_irq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_sel), .cfg_be(cfg_be[1:0]),
    .wdata(cfg_wdata[15:0]), .ctl_nx(ctl_nx), .sta_nx(sta_nx),
    .vec_o(msg_vec_o), .mode_o(mode), .irq_level_o(irq_level_o),
    .notify_o(msg_notify_o)
  );

  always_comb begin
    rd_word = '0;
    if (cfg_addr == ADDR_W'(CFG_ADDR)) begin
      rd_word[VEC_W-1:0] = msg_vec_o;
      rd_word[8]         = mode;
    end else if (cfg_addr == ADDR_W'(SLOT_ADDR)) begin
      rd_word = {sta_q, ctl_q};
    end else if (cfg_addr == ADDR_W'(CAP_ADDR)) begin
      rd_word = CAP_WORD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_word;
  end

  // R2: level needs the interrupt enable and level mode
  a_r2_level_gate: assert property (@(posedge clk) disable iff (rst)
    irq_level_o |-> (ctl_q[C_IRQ_EN] && !mode));
  // R5: the lock-toggle bit is never held
  a_r5_tgl_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_rd |=> !(($past(cfg_addr) == ADDR_W'(SLOT_ADDR)) && cfg_rdata[C_LOCK_TGL]));
endmodule

// File: tb/hp_slot_ctl_test.sv
module hp_slot_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_wr = 0, cfg_rd = 0;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_rdata;
  logic        evt_hot_add = 0, evt_unplug_req = 0;
  logic        irq_level_o, msg_notify_o, detach_o, busy_err_o;
  logic [4:0]  msg_vec_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_ctl, m_sta;
  logic        m_mode, m_pend;
  logic [4:0]  m_vec;
  logic        e_level, e_notify, e_detach, e_busy;

  hp_slot_ctl uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .evt_hot_add(evt_hot_add), .evt_unplug_req(evt_unplug_req),
    .irq_level_o(irq_level_o), .msg_notify_o(msg_notify_o), .msg_vec_o(msg_vec_o),
    .detach_o(detach_o), .busy_err_o(busy_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_word();
    return {m_sta, m_ctl};
  endfunction
  function automatic logic [31:0] cfg_word();
    return {23'd0, m_mode, 3'd0, m_vec};
  endfunction

  task automatic model_eval();
    logic p;
    p = m_ctl[5] && (|(m_ctl & m_sta & 16'h0019));
    e_level  = !m_mode && p;
    e_notify = m_mode && p && !m_pend;
    m_pend   = p;
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " R2 level"}, {31'd0, irq_level_o}, {31'd0, e_level});
    chk({tag, " R3 notify"}, {31'd0, msg_notify_o}, {31'd0, e_notify});
    if (e_notify) chk({tag, " R3 vector"}, {27'd0, msg_vec_o}, {27'd0, m_vec});
    chk({tag, " R6 detach"}, {31'd0, detach_o}, {31'd0, e_detach});
    chk({tag, " R9 busy"}, {31'd0, busy_err_o}, {31'd0, e_busy});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_ctl = 16'h00C0; m_sta = 0; m_mode = 0; m_vec = 0; m_pend = 0;
    e_level = 0; e_notify = 0; e_detach = 0; e_busy = 0;
  endtask

  task automatic op_wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d,
                       input string tag);
    logic [15:0] c;
    e_detach = 0; e_busy = 0;
    if (a == 2'd1) begin
      if (be[2]) m_sta = m_sta & ~(d[31:16] & 16'h0019);
      if (be[0] || be[1]) begin
        c = m_ctl;
        if (be[0]) c[7:0]  = (m_ctl[7:0] & ~8'hF9) | (d[7:0] & 8'hF9);
        if (be[1]) c[15:8] = (m_ctl[15:8] & ~8'h07) | (d[15:8] & 8'h07);
        m_ctl = c;
        if (be[1] && d[11]) m_sta[7] = ~m_sta[7];
        if (m_sta[6] && m_ctl[10] && m_ctl[9:8] == 2'b11) begin
          m_sta[6] = 0; m_sta[3] = 1; e_detach = 1;
        end
        m_sta[4] = 1;
      end
    end else if (a == 2'd0) begin
      if (be[0]) m_vec  = d[4:0];
      if (be[1]) m_mode = d[8];
    end
    model_eval();
    cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
    check_outs(tag);
  endtask

  task automatic op_evt(input bit hot, input string tag);
    e_detach = 0; e_busy = 0;
    if (hot) begin
      if (m_sta[7]) e_busy = 1;
      else m_sta = m_sta | 16'h0049;
    end else m_sta[0] = 1'b1;
    model_eval();
    evt_hot_add = hot; evt_unplug_req = !hot;
    @(negedge clk);
    evt_hot_add = 0; evt_unplug_req = 0;
    check_outs(tag);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    cfg_rd = 1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 0;
    chk(tag, cfg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();
    // R1 reset values
    chk("R1 level", {31'd0, irq_level_o}, 0);
    chk("R1 notify", {31'd0, msg_notify_o}, 0);
    rd_chk(2'd1, 32'h0000_00C0, "R1 slot word");
    rd_chk(2'd0, 32'h0, "R1 config word");
    rd_chk(2'd2, 32'h003A_0079, "R10 capability word");

    op_wr(2'd1, 4'b0001, 32'h0000_0039, "R4 enable command");
    chk("R4 level after command", {31'd0, irq_level_o}, 1);
    rd_chk(2'd1, slot_word(), "R4 slot word");
    op_wr(2'd1, 4'b0100, 32'h0010_0000, "R8 clear done");
    chk("R8 level dropped", {31'd0, irq_level_o}, 0);
    op_evt(1'b1, "R7 hot add");
    rd_chk(2'd1, slot_word(), "R7 slot word");
    chk("R7 bits set", {29'd0, cfg_rdata[22], cfg_rdata[19], cfg_rdata[16]}, 32'd7);
    op_wr(2'd0, 4'b0011, 32'h0000_0115, "R3 message mode on");
    op_wr(2'd1, 4'b0100, 32'h0019_0000, "R8 clear all events");
    op_evt(1'b0, "R3 unplug pulse");
    chk("R3 pulse seen", {31'd0, msg_notify_o}, 1);
    chk("R3 pulse vector", {27'd0, msg_vec_o}, 32'h15);
    op_evt(1'b0, "R3 repeat no pulse");
    chk("R3 no second pulse", {31'd0, msg_notify_o}, 0);
    op_wr(2'd1, 4'b0010, 32'h0000_0800, "R5 lock toggle");
    rd_chk(2'd1, slot_word(), "R5 slot word");
    chk("R5 locked bit", {31'd0, cfg_rdata[23]}, 1);
    chk("R5 toggle reads zero", {31'd0, cfg_rdata[11]}, 0);
    op_evt(1'b1, "R9 hot add locked");
    chk("R9 busy pulse", {31'd0, busy_err_o}, 1);
    rd_chk(2'd1, slot_word(), "R9 status unchanged");
    op_wr(2'd1, 4'b0010, 32'h0000_0800, "R5 unlock");
    op_wr(2'd1, 4'b0010, 32'h0000_0700, "R6 power off");
    chk("R6 detach pulse", {31'd0, detach_o}, 1);
    rd_chk(2'd1, slot_word(), "R6 slot word");
    op_wr(2'd1, 4'b1000, 32'hFFFF_FFFF, "R10 upper byte only");
    rd_chk(2'd1, slot_word(), "R10 slot unchanged");
    op_wr(2'd2, 4'b1111, 32'h0, "R10 capability write");
    rd_chk(2'd2, 32'h003A_0079, "R10 capability unchanged");
    rd_chk(2'd0, cfg_word(), "R3 config word");

    do_reset();
    rd_chk(2'd1, 32'h0000_00C0, "R1 slot after second reset");
    chk("R1 level after second reset", {31'd0, irq_level_o}, 0);

    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom % 6;
      case (k)
        0, 1: op_wr(2'd1, 4'($urandom), $urandom, "R4 random slot write");
        2:    op_wr(2'd0, 4'($urandom), $urandom, "R3 random config write");
        3:    op_evt(1'b1, "R7 random hot add");
        4:    op_evt(1'b0, "R7 random unplug");
        default: op_wr(2'd1, 4'b0100, {$urandom, 16'h0}, "R8 random clear");
      endcase
      rd_chk(2'd1, slot_word(), "R8 random slot word");
      if (i % 8 == 0) rd_chk(2'd0, cfg_word(), "R3 random config word");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule